// File: doc/BRIEF.md
# Trigger-Controlled Timebase Counter

This block is the free-running timebase that sits in front of a set of timer channels. The counter advances from zero up to a programmable modulo value, wraps back to zero, and on each wrap sets a sticky overflow flag. It also emits a one-cycle period-boundary strobe for the downstream channels. A clock-select field decides what clocks the counter: it can be stopped, stepped by every system clock, or stepped by an external tick input. A power-of-two prescaler divides whichever source is selected.

An input trigger, picked from a bank of lines and optionally inverted, layers extra control on top of the plain modulo count. It can hold the counter until the first trigger arrives, return the count to zero, or freeze the count for as long as it stays asserted. Separately, the counter can halt after its first overflow, and it can be frozen while the system is in a debug or doze state.

Top module: `trig_timebase`

## Requirements
- R1: After reset the count is 0, the overflow flag and the period strobe are low, and the clock-select readback is 0.
- R2: Clock-select code 0 stops the counter, code 1 advances it on system clocks, and codes 2 and 3 advance it only in cycles where the external tick is high. The readback shows the previous select value for one cycle after a change, so after a write of 0 it stays non-zero for one cycle. Once the readback is 0, the count is cleared to 0 on the next edge.
- R3: The 3-bit prescale code k advances the count once per 2^k source ticks (k = 0 gives divide by 1, k = 7 gives divide by 128). After enabling with code 1, the count reads floor((n-1)/2^k) n edges later.
- R4: The count runs 0..modulo inclusive. On the step past the modulo value it returns to 0, the overflow flag goes high, and the period strobe is high for exactly one cycle, all on the same edge.
- R5: The overflow flag stays set until the clear input is driven high, and clears on that edge. A wrap on the same edge wins over the clear.
- R6: A modulo write while the counter is stopped takes effect at once. A write while the counter runs takes effect at the next wrap. A modulo value of 0 is treated as 1.
- R7: The 4-bit trigger select picks one of 16 trigger lines, and the other lines are ignored. The invert input flips the selected line, and a trigger event is a rising edge of the corrected level.
- R8: With start-on-trigger set, the count stays at 0 until a trigger event. It advances from the edge after the event onward.
- R9: With reload-on-trigger set, a trigger event returns the count to 0 on the edge that detects it. A trigger held high causes only one reload.
- R10: With pause-on-trigger set, the count holds its value for every cycle that the corrected trigger level is high.
- R11: With stop-on-overflow set, the counter halts at 0 after its first wrap and stays there.
- R12: With debug active and debug-run low, the count holds. With doze active and doze-pause high, the count holds. Otherwise it keeps counting in those states.
- R13: Under an external clock select, each cycle with the external tick high advances the count by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clkSel | input | 2 | Counter clock select: 0 off, 1 system clock, 2/3 external tick |
| extTick | input | 1 | External clock-enable tick |
| prescale | input | 3 | Prescale exponent |
| modulo | input | CNT_W | New modulo value |
| modWrite | input | 1 | Strobe to write modulo |
| trigIn | input | TRIG_N | Trigger lines |
| trigSel | input | SEL_W | Trigger line select |
| trigInvert | input | 1 | Treat selected trigger as active-low |
| startOnTrig | input | 1 | Wait for a trigger before counting |
| reloadOnTrig | input | 1 | Trigger returns count to 0 |
| pauseOnTrig | input | 1 | Hold count while trigger level is high |
| stopOnOvf | input | 1 | Halt after first overflow |
| dbgMode | input | 1 | System is in debug state |
| dbgRun | input | 1 | Keep counting in debug state |
| dozeMode | input | 1 | System is in doze state |
| dozePause | input | 1 | Hold count in doze state |
| ovfClr | input | 1 | Write-1-to-clear strobe for overflow flag |
| count | output | CNT_W | Counter value |
| ovfFlag | output | 1 | Sticky overflow flag |
| periodStrobe | output | 1 | One-cycle pulse on each wrap |
| clkSelRb | output | 2 | Clock-select readback (stop acknowledgement) |

## Verification
The select register adds one edge of latency, so the count first moves on the second rising edge after the counter is enabled. After that, a step, a reload or a pause shows in the count one edge after the input that causes it. The overflow flag and the period strobe change on the same edge as the wrap to zero. The readback follows a select write one edge later, and the count clears one edge after that. The bench drives every input and samples every output on the falling clock edge, and it computes each expected count from the number of rising edges it has stepped since the stimulus.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  // Strobes passed from the control side to the count datapath each cycle
  typedef struct packed {
    logic advance;    // step the count by one
    logic wrap;       // this step passes the modulo value
    logic reload;     // trigger-driven return to zero
    logic clear;      // counter stopped: hold at zero
    logic modDirect;  // modulo writes land immediately
  } tbcStrobes_t;
endpackage

// File: rtl/tbc_ctrl.sv
module tbc_ctrl
  import tbc_pkg::*;
#(
  parameter int TRIG_N = 16,
  parameter int SEL_W  = 4,
  parameter int PS_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        clkSel,
  input  logic              extTick,
  input  logic [PS_W-1:0]   prescale,
  input  logic [TRIG_N-1:0] trigIn,
  input  logic [SEL_W-1:0]  trigSel,
  input  logic              trigInvert,
  input  logic              startOnTrig,
  input  logic              reloadOnTrig,
  input  logic              pauseOnTrig,
  input  logic              stopOnOvf,
  input  logic              dbgMode,
  input  logic              dbgRun,
  input  logic              dozeMode,
  input  logic              dozePause,
  input  logic              atTop,
  output tbcStrobes_t       strobes,
  output logic [1:0]        clkSelRb,
  output logic              trigLevel
);
  localparam int PSC_W = (1 << PS_W) - 1;

  logic [1:0]       selActive;
  logic             enabled;
  logic             srcTick;
  logic             trigQ;
  logic             trigEdge;
  logic             started;
  logic             halted;
  logic             paused;
  logic             gate;
  logic             psHit;
  logic [PSC_W-1:0] psCnt;
  logic [PSC_W-1:0] psMask;

  // Select register: the stop takes effect one edge after the write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selActive <= 2'd0;
    else       selActive <= clkSel;
  end

  assign enabled  = (selActive != 2'd0);
  assign clkSelRb = selActive;
  assign srcTick  = (selActive == 2'd1) ? 1'b1 : (enabled ? extTick : 1'b0);

  // Trigger selection, polarity correction, rising-edge detection
  assign trigLevel = trigIn[trigSel] ^ trigInvert;
  assign trigEdge  = trigLevel & ~trigQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trigQ <= 1'b0;
    else       trigQ <= trigLevel;
  end

  // Start and halt state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      started <= 1'b0;
      halted  <= 1'b0;
    end else if (!enabled) begin
      started <= 1'b0;
      halted  <= 1'b0;
    end else begin
      if (trigEdge) started <= 1'b1;
      if (strobes.wrap && stopOnOvf)    halted <= 1'b1;
      else if (trigEdge && startOnTrig) halted <= 1'b0;
    end
  end

  assign paused = (pauseOnTrig & trigLevel) | (dbgMode & ~dbgRun) | (dozeMode & dozePause);
  assign gate   = srcTick & (~startOnTrig | started) & ~halted & ~paused;

  // Prescaler mask: bit i is active when i is below the exponent
  for (genvar i = 0; i < PSC_W; i++) begin : g_mask
    assign psMask[i] = (PS_W'(i) < prescale);
  end

  assign psHit = ((psCnt & psMask) == psMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         psCnt <= '0;
    else if (!enabled || strobes.reload) psCnt <= '0;
    else if (gate)                     psCnt <= psCnt + 1'b1;
  end

  always_comb begin
    strobes.reload    = enabled & trigEdge & reloadOnTrig;
    strobes.advance   = enabled & gate & psHit & ~strobes.reload;
    strobes.wrap      = strobes.advance & atTop;
    strobes.clear     = ~enabled;
    strobes.modDirect = ~enabled;
  end
endmodule

// File: rtl/tbc_datapath.sv
module tbc_datapath
  import tbc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tbcStrobes_t      strobes,
  input  logic [CNT_W-1:0] modulo,
  input  logic             modWrite,
  input  logic             ovfClr,
  output logic [CNT_W-1:0] count,
  output logic             atTop,
  output logic             ovfFlag,
  output logic             periodStrobe
);
  localparam logic [CNT_W-1:0] MOD_MIN = CNT_W'(1);

  logic [CNT_W-1:0] modActive;
  logic [CNT_W-1:0] modPend;
  logic             pendValid;
  logic [CNT_W-1:0] modIn;

  assign modIn = (modulo == '0) ? MOD_MIN : modulo;
  assign atTop = (count == modActive);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   count <= '0;
    else if (strobes.clear || strobes.reload || strobes.wrap) count <= '0;
    else if (strobes.advance)                    count <= count + 1'b1;
  end

  // Modulo buffering: immediate while stopped, at the wrap while running
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modActive <= '1;
      modPend   <= '0;
      pendValid <= 1'b0;
    end else if (strobes.modDirect) begin
      pendValid <= 1'b0;
      if (modWrite) modActive <= modIn;
    end else begin
      if (strobes.wrap && pendValid) modActive <= modPend;
      if (modWrite) begin
        modPend   <= modIn;
        pendValid <= 1'b1;
      end else if (strobes.wrap) begin
        pendValid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag      <= 1'b0;
      periodStrobe <= 1'b0;
    end else begin
      periodStrobe <= strobes.wrap;
      if (strobes.wrap) ovfFlag <= 1'b1;
      else if (ovfClr)  ovfFlag <= 1'b0;
    end
  end

  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrap |=> (count == '0));

  p_strobe_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    periodStrobe |-> (ovfFlag && count == '0));

  p_ovf_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClr) |=> ovfFlag);
endmodule

// File: rtl/trig_timebase.sv
module trig_timebase
  import tbc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int TRIG_N = 16,
  parameter int PS_W   = 3,
  localparam int SEL_W = $clog2(TRIG_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        clkSel,
  input  logic              extTick,
  input  logic [PS_W-1:0]   prescale,
  input  logic [CNT_W-1:0]  modulo,
  input  logic              modWrite,
  input  logic [TRIG_N-1:0] trigIn,
  input  logic [SEL_W-1:0]  trigSel,
  input  logic              trigInvert,
  input  logic              startOnTrig,
  input  logic              reloadOnTrig,
  input  logic              pauseOnTrig,
  input  logic              stopOnOvf,
  input  logic              dbgMode,
  input  logic              dbgRun,
  input  logic              dozeMode,
  input  logic              dozePause,
  input  logic              ovfClr,
  output logic [CNT_W-1:0]  count,
  output logic              ovfFlag,
  output logic              periodStrobe,
  output logic [1:0]        clkSelRb
);
  tbcStrobes_t strobes;
  logic        atTop;
  logic        trigLevel;

  tbc_ctrl #(.TRIG_N(TRIG_N), .SEL_W(SEL_W), .PS_W(PS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .extTick(extTick),
    .prescale(prescale), .trigIn(trigIn), .trigSel(trigSel),
    .trigInvert(trigInvert), .startOnTrig(startOnTrig),
    .reloadOnTrig(reloadOnTrig), .pauseOnTrig(pauseOnTrig),
    .stopOnOvf(stopOnOvf), .dbgMode(dbgMode), .dbgRun(dbgRun),
    .dozeMode(dozeMode), .dozePause(dozePause), .atTop(atTop),
    .strobes(strobes), .clkSelRb(clkSelRb), .trigLevel(trigLevel)
  );

  tbc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .modulo(modulo),
    .modWrite(modWrite), .ovfClr(ovfClr), .count(count), .atTop(atTop),
    .ovfFlag(ovfFlag), .periodStrobe(periodStrobe)
  );

  p_stop_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    (clkSelRb == 2'd0) |=> (count == '0));

  p_pause_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pauseOnTrig && trigLevel && !reloadOnTrig && clkSelRb != 2'd0) |=> $stable(count));

  p_halt_r11: assert property (@(posedge clk) disable iff (!rstN)
    (periodStrobe && stopOnOvf && $past(stopOnOvf) && !startOnTrig && !reloadOnTrig)
      |=> (count == '0));
endmodule

// File: tb/tb_trig_timebase.sv
module tb_trig_timebase;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [1:0]       clkSel = '0;
  logic             extTick = 1'b0;
  logic [2:0]       prescale = '0;
  logic [CNT_W-1:0] modulo = '0;
  logic             modWrite = 1'b0;
  logic [15:0]      trigIn = '0;
  logic [3:0]       trigSel = '0;
  logic             trigInvert = 1'b0;
  logic             startOnTrig = 1'b0, reloadOnTrig = 1'b0, pauseOnTrig = 1'b0;
  logic             stopOnOvf = 1'b0;
  logic             dbgMode = 1'b0, dbgRun = 1'b0, dozeMode = 1'b0, dozePause = 1'b0;
  logic             ovfClr = 1'b0;
  logic [CNT_W-1:0] count;
  logic             ovfFlag, periodStrobe;
  logic [1:0]       clkSelRb;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  trig_timebase dut (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .extTick(extTick),
    .prescale(prescale), .modulo(modulo), .modWrite(modWrite),
    .trigIn(trigIn), .trigSel(trigSel), .trigInvert(trigInvert),
    .startOnTrig(startOnTrig), .reloadOnTrig(reloadOnTrig),
    .pauseOnTrig(pauseOnTrig), .stopOnOvf(stopOnOvf), .dbgMode(dbgMode),
    .dbgRun(dbgRun), .dozeMode(dozeMode), .dozePause(dozePause),
    .ovfClr(ovfClr), .count(count), .ovfFlag(ovfFlag),
    .periodStrobe(periodStrobe), .clkSelRb(clkSelRb)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Stop, clear flag, load modulo directly, then enable with the given select
  task automatic restart(input logic [1:0] sel, input logic [2:0] ps, input int m);
    clkSel = 2'd0;
    ovfClr = 1'b1;
    step(3);
    ovfClr   = 1'b0;
    modulo   = CNT_W'(m);
    modWrite = 1'b1;
    step(1);
    modWrite = 1'b0;
    prescale = ps;
    clkSel   = sel;
  endtask

  task automatic t_reset();
    chk("R1", "count", int'(count), 0);
    chk("R1", "ovf", int'(ovfFlag), 0);
    chk("R1", "strobe", int'(periodStrobe), 0);
    chk("R1", "readback", int'(clkSelRb), 0);
  endtask

  task automatic t_select_stop();
    restart(2'd1, 3'd0, 100);
    step(10);
    chk("R2", "count running", int'(count), 9);
    chk("R2", "readback on", int'(clkSelRb), 1);
    clkSel = 2'd0;
    #1;
    chk("R2", "readback before ack", int'(clkSelRb), 1);
    step(1);
    chk("R2", "readback after ack", int'(clkSelRb), 0);
    chk("R2", "last step", int'(count), 10);
    step(1);
    chk("R2", "cleared", int'(count), 0);
    step(3);
    chk("R2", "stays stopped", int'(count), 0);
  endtask

  task automatic t_prescale();
    restart(2'd1, 3'd3, 1000);
    step(17);
    chk("R3", "div8 count", int'(count), 2);
    step(8);
    chk("R3", "div8 next", int'(count), 3);
    restart(2'd1, 3'd7, 1000);
    step(128);
    chk("R3", "div128 before", int'(count), 0);
    step(1);
    chk("R3", "div128 step", int'(count), 1);
  endtask

  task automatic t_wrap_clear();
    restart(2'd1, 3'd0, 4);
    step(5);
    chk("R4", "at top", int'(count), 4);
    chk("R4", "no ovf yet", int'(ovfFlag), 0);
    step(1);
    chk("R4", "wrapped", int'(count), 0);
    chk("R4", "ovf set", int'(ovfFlag), 1);
    chk("R4", "strobe", int'(periodStrobe), 1);
    step(1);
    chk("R4", "strobe one cycle", int'(periodStrobe), 0);
    chk("R5", "ovf sticky", int'(ovfFlag), 1);
    ovfClr = 1'b1;
    step(1);
    ovfClr = 1'b0;
    chk("R5", "ovf cleared", int'(ovfFlag), 0);
    // count now 2; wrap lands 3 edges later with clear held: wrap wins
    step(2);
    ovfClr = 1'b1;
    step(1);
    ovfClr = 1'b0;
    chk("R5", "wrap beats clear count", int'(count), 0);
    chk("R5", "wrap beats clear", int'(ovfFlag), 1);
  endtask

  task automatic t_modulo();
    restart(2'd1, 3'd0, 7);
    step(3);
    chk("R6", "pre write", int'(count), 2);
    modulo   = CNT_W'(2);
    modWrite = 1'b1;
    step(1);
    modWrite = 1'b0;
    step(4);
    chk("R6", "old modulo kept", int'(count), 7);
    step(1);
    chk("R6", "wrap old", int'(count), 0);
    step(2);
    chk("R6", "new top", int'(count), 2);
    step(1);
    chk("R6", "wrap new", int'(count), 0);
    restart(2'd1, 3'd0, 0);
    step(2);
    chk("R6", "zero as one top", int'(count), 1);
    step(1);
    chk("R6", "zero as one wrap", int'(count), 0);
  endtask

  task automatic t_start();
    startOnTrig = 1'b1;
    trigSel     = 4'd2;
    restart(2'd1, 3'd0, 100);
    step(5);
    chk("R8", "waiting", int'(count), 0);
    trigIn[5] = 1'b1;
    step(2);
    trigIn[5] = 1'b0;
    step(2);
    chk("R7", "other line ignored", int'(count), 0);
    trigIn[2] = 1'b1;
    step(4);
    chk("R8", "started", int'(count), 3);
    trigIn[2]   = 1'b0;
    startOnTrig = 1'b0;
  endtask

  task automatic t_reload();
    reloadOnTrig = 1'b1;
    trigSel      = 4'd1;
    restart(2'd1, 3'd0, 100);
    step(21);
    chk("R9", "pre reload", int'(count), 20);
    trigIn[1] = 1'b1;
    step(1);
    chk("R9", "reloaded", int'(count), 0);
    step(2);
    chk("R9", "single reload on held level", int'(count), 2);
    trigIn[1] = 1'b0;
    // inverted trigger: a falling line is the event
    trigSel    = 4'd3;
    trigIn[3]  = 1'b1;
    trigInvert = 1'b1;
    restart(2'd1, 3'd0, 100);
    step(11);
    chk("R7", "inverted idle", int'(count), 10);
    trigIn[3] = 1'b0;
    step(1);
    chk("R7", "inverted event reload", int'(count), 0);
    trigIn[3] = 1'b1;
    step(2);
    chk("R7", "raw rise no reload", int'(count), 2);
    trigIn[3]    = 1'b0;
    trigInvert   = 1'b0;
    reloadOnTrig = 1'b0;
  endtask

  task automatic t_pause();
    pauseOnTrig = 1'b1;
    trigSel     = 4'd4;
    restart(2'd1, 3'd0, 100);
    step(6);
    chk("R10", "pre pause", int'(count), 5);
    trigIn[4] = 1'b1;
    step(5);
    chk("R10", "held", int'(count), 5);
    trigIn[4] = 1'b0;
    step(3);
    chk("R10", "resumed", int'(count), 8);
    pauseOnTrig = 1'b0;
  endtask

  task automatic t_stop_ovf();
    stopOnOvf = 1'b1;
    restart(2'd1, 3'd0, 3);
    step(5);
    chk("R11", "wrapped", int'(count), 0);
    chk("R11", "ovf", int'(ovfFlag), 1);
    step(10);
    chk("R11", "halted", int'(count), 0);
    chk("R11", "no second strobe", int'(periodStrobe), 0);
    stopOnOvf = 1'b0;
  endtask

  task automatic t_dbg_doze();
    restart(2'd1, 3'd0, 100);
    step(4);
    chk("R12", "pre debug", int'(count), 3);
    dbgMode = 1'b1;
    step(5);
    chk("R12", "debug freeze", int'(count), 3);
    dbgRun = 1'b1;
    step(5);
    chk("R12", "debug run", int'(count), 8);
    dbgMode   = 1'b0;
    dbgRun    = 1'b0;
    dozeMode  = 1'b1;
    dozePause = 1'b1;
    step(4);
    chk("R12", "doze freeze", int'(count), 8);
    dozePause = 1'b0;
    step(2);
    chk("R12", "doze run", int'(count), 10);
    dozeMode = 1'b0;
  endtask

  task automatic t_ext();
    restart(2'd2, 3'd0, 100);
    step(3);
    chk("R13", "no tick", int'(count), 0);
    for (int i = 0; i < 5; i++) begin
      extTick = 1'b1;
      step(1);
      extTick = 1'b0;
      step(1);
    end
    chk("R13", "five ticks", int'(count), 5);
    chk("R2", "ext select readback", int'(clkSelRb), 2);
  endtask

  initial begin
    step(2);
    rstN = 1'b1;
    step(1);
    t_reset();
    t_select_stop();
    t_prescale();
    t_wrap_clear();
    t_modulo();
    t_start();
    t_reload();
    t_pause();
    t_stop_ovf();
    t_dbg_doze();
    t_ext();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule